// File: doc/BRIEF.md
# Machine Check Bank Error Logger

This block records hardware error reports in a small array of machine-check banks. Each bank keeps a status word, an error address and a miscellaneous word. A single global status word sits beside the banks. A caller offers one injection request per cycle. The request carries a target bank, a status word, a replacement global status word, address, misc and an unconditional flag. The block decides whether to reject, ignore, drop, escalate or log the request.

Uncorrected errors take priority. When they are allowed, they overwrite the bank and raise a one-cycle machine-check interrupt. When the machine-check path is disabled, or a previous check is still being handled, they raise a one-cycle reset request instead. Corrected errors never displace a pending uncorrected error; they only mark overflow in it.

The capability word, the global control word, the per-bank control words and the machine-check enable come in as static configuration inputs. A handler-done input clears the in-progress bit of the global status once the interrupt has been served.

Top module: `mcb_logger`

## Requirements
- R1: A request gets result 3 (rejected) and changes no state in any of these cases: the capability word is zero; the bank index is at or above capability bits 7:0; the bank index is at or above NUM_BANKS; or status bit 63 (valid) is clear.
- R2: A request that is valid, has status bit 55 (action required) clear and the unconditional flag low gets result 2 (ignored), with no state change, while global status bit 2 (in progress) is set.
- R3: An uncorrected request (status bit 61 set) that passes R1 and R2 gets result 4 (dropped), with no state change, in two cases: capability bit 8 (control present) is set and the global control word is not all ones; or the target bank's control word is not all ones.
- R4: An uncorrected request that passes R1 to R3 gets result 5. It raises reset_req_o for exactly one cycle and logs nothing when mce_enable is low or the in-progress bit is already set.
- R5: Any other uncorrected request gets result 1. It writes the bank status, with bit 62 (overflow) forced on if the old status was valid, and writes the bank address and misc. It loads the global status from the request and pulses irq_o for one cycle.
- R6: A corrected request into a bank whose status is not both valid and uncorrected gets result 1. It writes status, address and misc, with overflow forced on if the old status was valid. It leaves the global status alone and raises no interrupt.
- R7: A corrected request into a bank holding a valid uncorrected error gets result 1 and only sets overflow (bit 62) in that bank's status. The address, the misc word and every other status bit are kept.
- R8: result_o, irq_o and reset_req_o are registered and refer to the request of the previous cycle. Result codes are 0 none, 1 logged, 2 ignored, 3 rejected, 4 dropped, 5 reset. With no request the result is 0, and both pulses stay low.
- R9: handler_done clears only bit 2 of the global status. A global status load under R5 in the same cycle takes priority over the clear.
- R10: After reset all bank words and the global status are zero, the result is 0 and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Injection request present this cycle |
| req_bank | input | BANK_W | Target bank index |
| req_status | input | 64 | Bank status word to log |
| req_gstat | input | 64 | Global status word loaded with an uncorrected log |
| req_addr | input | 64 | Error address word |
| req_misc | input | 64 | Miscellaneous error word |
| req_uncond | input | 1 | Inject even while a check is in progress |
| mce_enable | input | 1 | Machine-check delivery enabled |
| cap_word | input | 64 | Capability: bits 7:0 bank count, bit 8 control present |
| gctl_word | input | 64 | Global control word |
| bank_ctl | input | NUM_BANKS*64 | Per-bank control words, bank b at bits b*64 and up |
| handler_done | input | 1 | Clears the in-progress bit of the global status |
| irq_o | output | 1 | One-cycle machine-check interrupt |
| reset_req_o | output | 1 | One-cycle reset request |
| result_o | output | 3 | Result code of the previous cycle's request |
| gstat_o | output | 64 | Global status word |
| bank_status_o | output | NUM_BANKS*64 | Bank status words |
| bank_addr_o | output | NUM_BANKS*64 | Bank address words |
| bank_misc_o | output | NUM_BANKS*64 | Bank misc words |

## Verification
Directed sequences walk one bank through every logging path: empty, then corrected, then corrected again, then uncorrected, then corrected on top of the uncorrected error. This separates plain logging from overflow marking and from the overflow-only update. Further directed cases vary one input at a time: the in-progress bit, the action-required bit, the unconditional flag, the enable, the global control word and the bank control words. Each of these moves a single request between the ignored, dropped, reset and logged outcomes, which shows the decision order. A seeded random stream then mixes out-of-range banks, invalid status, control words that are not all ones and handler-done pulses, with random occupancy of the banks.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
   localparam int W        = 64;
   localparam int ST_VAL   = 63;
   localparam int ST_OVER  = 62;
   localparam int ST_UC    = 61;
   localparam int ST_AR    = 55;
   localparam int GS_MCIP  = 2;
   localparam int CAP_CTLP = 8;
   localparam int CAP_CNT_W = 8;

   typedef enum logic [2:0] {
      RES_NONE     = 3'd0,
      RES_LOGGED   = 3'd1,
      RES_IGNORED  = 3'd2,
      RES_REJECTED = 3'd3,
      RES_DROPPED  = 3'd4,
      RES_RESET    = 3'd5
   } res_e;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_REJECT,
      ACT_IGNORE,
      ACT_DROP,
      ACT_RESET,
      ACT_LOG_UC,
      ACT_LOG_CE,
      ACT_MARK_OVER
   } act_e;

   function automatic res_e act_to_res(act_e a);
      case (a)
         ACT_NONE:   return RES_NONE;
         ACT_REJECT: return RES_REJECTED;
         ACT_IGNORE: return RES_IGNORED;
         ACT_DROP:   return RES_DROPPED;
         ACT_RESET:  return RES_RESET;
         default:    return RES_LOGGED;
      endcase
   endfunction
endpackage

// File: rtl/mcb_classify.sv
module mcb_classify
   import mcb_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 8
) (
   input  logic              req_valid,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [W-1:0]      req_status,
   input  logic              req_uncond,
   input  logic              mce_enable,
   input  logic [W-1:0]      cap_word,
   input  logic [W-1:0]      gctl_word,
   input  logic [W-1:0]      sel_ctl,
   input  logic [W-1:0]      sel_status,
   input  logic              mcip,
   output act_e              act
);
   logic bad_bank;
   logic ctl_off;

   always_comb begin
      bad_bank = (32'(req_bank) >= 32'(cap_word[CAP_CNT_W-1:0])) ||
                 (32'(req_bank) >= 32'(NUM_BANKS));
      ctl_off  = (cap_word[CAP_CTLP] && (gctl_word != '1)) || (sel_ctl != '1);
      act      = ACT_NONE;
      if (req_valid) begin
         if ((cap_word == '0) || bad_bank || !req_status[ST_VAL])
            act = ACT_REJECT;
         else if (!req_status[ST_AR] && !req_uncond && mcip)
            act = ACT_IGNORE;
         else if (req_status[ST_UC]) begin
            if (ctl_off)
               act = ACT_DROP;
            else if (!mce_enable || mcip)
               act = ACT_RESET;
            else
               act = ACT_LOG_UC;
         end
         else if (sel_status[ST_VAL] && sel_status[ST_UC])
            act = ACT_MARK_OVER;
         else
            act = ACT_LOG_CE;
      end
   end
endmodule

// File: rtl/mcb_bank.sv
module mcb_bank
   import mcb_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_log,
   input  logic         wr_over,
   input  logic [W-1:0] new_status,
   input  logic [W-1:0] new_addr,
   input  logic [W-1:0] new_misc,
   output logic [W-1:0] status,
   output logic [W-1:0] addr,
   output logic [W-1:0] misc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         addr   <= '0;
         misc   <= '0;
      end else if (wr_log) begin
         status <= new_status;
         addr   <= new_addr;
         misc   <= new_misc;
      end else if (wr_over) begin
         status[ST_OVER] <= 1'b1;
      end
   end
endmodule

// File: rtl/mcb_logger.sv
module mcb_logger
   import mcb_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [BANK_W-1:0]      req_bank,
   input  logic [63:0]            req_status,
   input  logic [63:0]            req_gstat,
   input  logic [63:0]            req_addr,
   input  logic [63:0]            req_misc,
   input  logic                   req_uncond,
   input  logic                   mce_enable,
   input  logic [63:0]            cap_word,
   input  logic [63:0]            gctl_word,
   input  logic [NUM_BANKS*64-1:0] bank_ctl,
   input  logic                   handler_done,
   output logic                   irq_o,
   output logic                   reset_req_o,
   output logic [2:0]             result_o,
   output logic [63:0]            gstat_o,
   output logic [NUM_BANKS*64-1:0] bank_status_o,
   output logic [NUM_BANKS*64-1:0] bank_addr_o,
   output logic [NUM_BANKS*64-1:0] bank_misc_o
);
   localparam int MAX_BANKS = (1 << CAP_CNT_W) - 1;

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("NUM_BANKS out of range");
   end
   if (BANK_W < 1 || BANK_W > 16 || (1 << BANK_W) < NUM_BANKS) begin : g_bad_bank_w
      $error("BANK_W cannot address NUM_BANKS");
   end

   logic [W-1:0]         st   [NUM_BANKS];
   logic [NUM_BANKS-1:0] hit;
   logic [W-1:0]         sel_ctl, sel_status, merged_status, gstat_q;
   act_e                 act;
   res_e                 result_q;
   logic                 irq_q, rst_q;

   always_comb begin
      sel_ctl    = '0;
      sel_status = '0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (hit[i]) begin
            sel_ctl    = bank_ctl[i*W +: W];
            sel_status = st[i];
         end
      end
      merged_status          = req_status;
      merged_status[ST_OVER] = req_status[ST_OVER] | sel_status[ST_VAL];
   end

   mcb_classify #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_classify (
      .req_valid  (req_valid),
      .req_bank   (req_bank),
      .req_status (req_status),
      .req_uncond (req_uncond),
      .mce_enable (mce_enable),
      .cap_word   (cap_word),
      .gctl_word  (gctl_word),
      .sel_ctl    (sel_ctl),
      .sel_status (sel_status),
      .mcip       (gstat_q[GS_MCIP]),
      .act        (act)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign hit[b] = (32'(req_bank) == 32'(b));
      mcb_bank u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_log     (hit[b] && ((act == ACT_LOG_UC) || (act == ACT_LOG_CE))),
         .wr_over    (hit[b] && (act == ACT_MARK_OVER)),
         .new_status (merged_status),
         .new_addr   (req_addr),
         .new_misc   (req_misc),
         .status     (st[b]),
         .addr       (bank_addr_o[b*W +: W]),
         .misc       (bank_misc_o[b*W +: W])
      );
      assign bank_status_o[b*W +: W] = st[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= RES_NONE;
         irq_q    <= 1'b0;
         rst_q    <= 1'b0;
         gstat_q  <= '0;
      end else begin
         result_q <= act_to_res(act);
         irq_q    <= (act == ACT_LOG_UC);
         rst_q    <= (act == ACT_RESET);
         if (act == ACT_LOG_UC)
            gstat_q <= req_gstat;
         else if (handler_done)
            gstat_q[GS_MCIP] <= 1'b0;
      end
   end

   assign result_o    = result_q;
   assign irq_o       = irq_q;
   assign reset_req_o = rst_q;
   assign gstat_o     = gstat_q;
endmodule

// File: rtl/mcb_logger_chk.sv
module mcb_logger_chk
   import mcb_pkg::*;
#(
   parameter int NUM_BANKS = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic                   irq_o,
   input logic                   reset_req_o,
   input logic [2:0]             result_o,
   input logic [NUM_BANKS*64-1:0] bank_status_o
);
   // R5: an interrupt only accompanies a logged result
   a_r5_irq_logged: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (result_o == 3'd1));

   // R4: a reset request only accompanies the reset result
   a_r4_reset_code: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req_o |-> (result_o == 3'd5));

   // R8: nothing reported without a request in the cycle before
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid) |-> ((result_o == 3'd0) && !irq_o && !reset_req_o));

   // R1: a rejected request leaves every bank status unchanged
   a_r1_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (result_o == 3'd3) |-> $stable(bank_status_o));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sticky
      // R7: a valid bank never loses its valid bit
      a_r7_val_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         $past(bank_status_o[b*64 + ST_VAL]) |-> bank_status_o[b*64 + ST_VAL]);
   end
endmodule

bind mcb_logger mcb_logger_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .irq_o         (irq_o),
   .reset_req_o   (reset_req_o),
   .result_o      (result_o),
   .bank_status_o (bank_status_o)
);

// File: tb/mcb_logger_tb_top.sv
module mcb_logger_tb_top;
   localparam int NB = 4;
   localparam int BW = 8;
   localparam int W  = 64;
   localparam logic [W-1:0] ONES = {W{1'b1}};
   localparam logic [W-1:0] VAL = 64'h8000_0000_0000_0000;
   localparam logic [W-1:0] UC  = 64'h2000_0000_0000_0000;
   localparam logic [W-1:0] AR  = 64'h0080_0000_0000_0000;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, req_valid, req_uncond, mce_enable, handler_done;
   logic [BW-1:0] req_bank;
   logic [W-1:0]  req_status, req_gstat, req_addr, req_misc, cap_word, gctl_word;
   logic [NB*W-1:0] bank_ctl;
   logic irq_o, reset_req_o;
   logic [2:0] result_o;
   logic [W-1:0] gstat_o;
   logic [NB*W-1:0] bank_status_o, bank_addr_o, bank_misc_o;

   mcb_logger #(.NUM_BANKS(NB), .BANK_W(BW)) dut_i (.*);

   int n_chk = 0, n_fail = 0;
   logic [W-1:0] m_st [NB], m_ad [NB], m_mi [NB];
   logic [W-1:0] m_gs;

   task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic predict(output logic [2:0] er, output logic ei, output logic erst,
                          output string tag);
      int b;
      logic mcip;
      logic [W-1:0] ns;
      b = int'(req_bank);
      mcip = m_gs[2];
      er = 3'd0; ei = 1'b0; erst = 1'b0; tag = "R8";
      if (handler_done) m_gs[2] = 1'b0;
      if (!req_valid) return;
      if (cap_word == 0 || b >= int'(cap_word[7:0]) || b >= NB || !req_status[63]) begin
         er = 3'd3; tag = "R1";
      end else if (!req_status[55] && !req_uncond && mcip) begin
         er = 3'd2; tag = "R2";
      end else if (req_status[61]) begin
         if ((cap_word[8] && gctl_word != ONES) || bank_ctl[b*W +: W] != ONES) begin
            er = 3'd4; tag = "R3";
         end else if (!mce_enable || mcip) begin
            er = 3'd5; erst = 1'b1; tag = "R4";
         end else begin
            ns = req_status; ns[62] = ns[62] | m_st[b][63];
            m_st[b] = ns; m_ad[b] = req_addr; m_mi[b] = req_misc; m_gs = req_gstat;
            er = 3'd1; ei = 1'b1; tag = "R5";
         end
      end else if (m_st[b][63] && m_st[b][61]) begin
         m_st[b][62] = 1'b1; er = 3'd1; tag = "R7";
      end else begin
         ns = req_status; ns[62] = ns[62] | m_st[b][63];
         m_st[b] = ns; m_ad[b] = req_addr; m_mi[b] = req_misc;
         er = 3'd1; tag = "R6";
      end
   endtask

   task automatic step();
      logic [2:0] er;
      logic ei, erst;
      string tag;
      predict(er, ei, erst, tag);
      @(negedge clk);
      chk({tag, " result"}, 64'(result_o), 64'(er));
      chk({tag, " irq"}, 64'(irq_o), 64'(ei));
      chk({tag, " reset_req"}, 64'(reset_req_o), 64'(erst));
      chk({tag, " gstat"}, gstat_o, m_gs);
      for (int b = 0; b < NB; b++) begin
         chk({tag, " bank status"}, bank_status_o[b*W +: W], m_st[b]);
         chk({tag, " bank addr"}, bank_addr_o[b*W +: W], m_ad[b]);
         chk({tag, " bank misc"}, bank_misc_o[b*W +: W], m_mi[b]);
      end
      req_valid = 1'b0;
      handler_done = 1'b0;
   endtask

   task automatic req(int bank, logic [W-1:0] st, logic [W-1:0] gs, logic unc);
      req_valid  = 1'b1;
      req_bank   = BW'(bank);
      req_status = st;
      req_gstat  = gs;
      req_uncond = unc;
      req_addr   = {$urandom, $urandom};
      req_misc   = {$urandom, $urandom};
      step();
   endtask

   task automatic idle(logic done);
      req_valid = 1'b0;
      handler_done = done;
      step();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_status = '0; req_gstat = '0;
      req_addr = '0; req_misc = '0; req_uncond = 1'b0; mce_enable = 1'b1;
      handler_done = 1'b0; cap_word = 64'h104; gctl_word = ONES; bank_ctl = {NB*W{1'b1}};
      m_gs = '0;
      for (int b = 0; b < NB; b++) begin m_st[b] = '0; m_ad[b] = '0; m_mi[b] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state
      chk("R10 result", 64'(result_o), 64'd0);
      chk("R10 irq", 64'(irq_o), 64'd0);
      chk("R10 reset_req", 64'(reset_req_o), 64'd0);
      chk("R10 gstat", gstat_o, 64'd0);
      chk("R10 bank status", bank_status_o[W-1:0], 64'd0);
      idle(1'b0);                                     // R8 idle
      req(0, VAL | 64'h11, 64'd0, 1'b0);              // R6 empty bank
      req(0, VAL | 64'h12, 64'd0, 1'b0);              // R6 overflow on CE
      req(1, VAL | UC | AR, 64'h5, 1'b0);             // R5 UC log
      req(2, VAL | UC | AR, 64'h5, 1'b0);             // R4 MCIP set
      req(3, VAL | 64'h21, 64'd0, 1'b0);              // R2 ignored
      req(3, VAL | 64'h22, 64'd0, 1'b1);              // R6 unconditional
      req(1, VAL | AR | 64'h33, 64'd0, 1'b0);         // R7 over only
      idle(1'b1);                                     // R9 clear
      chk("R9 mcip cleared", 64'(gstat_o[2]), 64'd0);
      chk("R9 ripv kept", 64'(gstat_o[0]), 64'd1);
      req(4, VAL | UC, 64'h5, 1'b0);                  // R1 bank >= NUM_BANKS
      req(2, UC | 64'h1, 64'h5, 1'b0);                // R1 VAL clear
      cap_word = 64'h0;
      req(0, VAL, 64'd0, 1'b0);                       // R1 no capability
      cap_word = 64'h102;
      req(3, VAL, 64'd0, 1'b0);                       // R1 bank >= count
      cap_word = 64'h104; gctl_word = 64'h0F;
      req(2, VAL | UC | AR, 64'h5, 1'b0);             // R3 global ctl
      cap_word = 64'h004;
      req(2, VAL | UC | AR, 64'h5, 1'b0);             // R5 ctl not present
      idle(1'b1);
      cap_word = 64'h104; gctl_word = ONES; bank_ctl[3*W +: W] = 64'h1;
      req(3, VAL | UC | AR, 64'h5, 1'b0);             // R3 bank ctl
      bank_ctl[3*W +: W] = ONES; mce_enable = 1'b0;
      req(3, VAL | UC | AR, 64'h5, 1'b0);             // R4 disabled
      mce_enable = 1'b1;
      handler_done = 1'b1;
      req(3, VAL | UC | AR, 64'h5, 1'b0);             // R9 load beats clear
      chk("R9 load priority", 64'(gstat_o[2]), 64'd1);
      idle(1'b1);
      for (int i = 0; i < 600; i++) begin
         int pick;
         pick = $urandom_range(0, 9);
         cap_word = (pick == 0) ? 64'h0 : (pick == 1) ? 64'h103 : (pick == 2) ? 64'h004 : 64'h104;
         gctl_word = ($urandom_range(0, 7) == 0) ? {$urandom, $urandom} : ONES;
         for (int b = 0; b < NB; b++)
            bank_ctl[b*W +: W] = ($urandom_range(0, 9) == 0) ? 64'h7 : ONES;
         mce_enable = ($urandom_range(0, 7) != 0);
         handler_done = ($urandom_range(0, 2) == 0);
         req_valid = ($urandom_range(0, 5) != 0);
         req_bank = BW'($urandom_range(0, 5));
         req_status = {$urandom, $urandom};
         req_status[63] = ($urandom_range(0, 7) != 0);
         req_gstat = {$urandom, $urandom};
         req_uncond = ($urandom_range(0, 3) == 0);
         req_addr = {$urandom, $urandom};
         req_misc = {$urandom, $urandom};
         step();
      end
      summary();
      $finish;
   end
endmodule